// File: doc/BRIEF.md
# Prescaled External Input Sampling Timer

This block is a counter that takes its external inputs only at a slow, prescaled rate. A free-running divider makes a one-cycle sampling strobe from the system clock. A 2-bit select code sets the strobe period to 4, 8, 16 or 32 system clocks, and the codes are not in rising order. Each external pin first passes through a two-stage synchroniser on the system clock. The synchronised level is then captured only when the strobe fires. Between strobes the pin is not looked at, so a level that is shorter than one strobe period can be lost. The fastest input that is always counted correctly toggles at half the strobe rate.

A small controller state machine follows a mode select input and has three states. In ST_IDLE the counter is stopped. In ST_GATED the counter advances once per strobe while the gate pin is sampled high. In ST_COUNT the counter advances on transitions of the count pin: rising, falling or both, as chosen by the edge select. A transition is seen only when two successive strobe samples differ. The first sample after reset has no earlier sample to compare with, so it never counts as an edge.

The state transitions are named by their target. GO_IDLE happens on mode code 00 or 11. GO_GATED happens on code 01. GO_COUNT happens on code 10. The state register takes the requested state on every clock, from any state, so a mode change affects counting one clock later. The counter wraps from all ones to zero and raises an overflow flag for one clock.

Top module: `ext_sample_timer`

## Requirements
- R1: While synchronous active-high reset is applied, and in the first clock after it is removed, `count` is 0 and `ovf` is 0. Reset also clears the divider, the synchroniser and the sample registers, and puts the controller in ST_IDLE.
- R2: The strobe period set by `presc_sel` is 4 clocks for 01, 8 for 00, 16 for 11 and 32 for 10. In gated mode with the gate held high, `count` rises by exactly one per period.
- R3: Pins are taken through two synchroniser flops and are captured only on strobe cycles. A count-pin pulse that lies entirely between two strobes causes no count in any edge setting.
- R4: In counter mode, `count` rises by one for each recognised transition, meaning two successive strobe samples that differ. The `edge_sel` codes are 01 rising only, 10 falling only, 11 both edges, and 00 none.
- R5: The first strobe sample after reset is never treated as a transition, even when the count pin is high.
- R6: In gated mode, `count` rises by one on each strobe at which the sampled gate level is 1. It holds while the gate is sampled 0, and it never changes on a clock without a strobe.
- R7: The `run_mode` codes are 00 stop, 01 gated timer, 10 counter and 11 stop. In stop, `count` holds whatever the pins do.
- R8: An increment at the maximum value wraps `count` to 0. In that same clock `ovf` is 1, and on the next clock `ovf` is 0 again.
- R9: When `presc_sel` changes, the divider restarts. No increment happens for the first P_new-1 clocks after the clock edge that sees the change. The first strobe-driven increment lands exactly P_new edges after that edge, where P_new is the period of the new code.
- R10: A count pin that toggles every P clocks, so that each level lasts one full period, is counted with no loss in both-edge mode. 20 toggles give +20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 2 | Strobe period code (01:/4, 00:/8, 11:/16, 10:/32) |
| run_mode | input | 2 | 00 stop, 01 gated timer, 10 counter, 11 stop |
| edge_sel | input | 2 | Counter-mode edges: 00 none, 01 rising, 10 falling, 11 both |
| cnt_pin | input | 1 | External count input (asynchronous) |
| gate_pin | input | 1 | External gate input (asynchronous) |
| count | output | CNT_W | Counter value |
| ovf | output | 1 | One-clock pulse when the counter wraps to zero |

## Verification
The hardest case to reach is a count pulse that is missed because it lies between strobes. Hitting it on purpose needs a known strobe phase. The stimulus gets that phase by changing the prescaler code on a chosen clock: the restart puts the next strobe at a known cycle, and a short pulse is then placed well away from it. The restart itself is timed from the same edge, and both checks are exact to the cycle. Wrap and overflow are reached by building the bench with a narrower counter width.

// File: rtl/est_pkg.sv
package est_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATED = 2'd1,
        ST_COUNT = 2'd2
    } est_state_e;

    localparam logic [1:0] MODE_STOP  = 2'b00;
    localparam logic [1:0] MODE_GATED = 2'b01;
    localparam logic [1:0] MODE_COUNT = 2'b10;
    localparam logic [1:0] MODE_RSVD  = 2'b11;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    // Rank of a select code in the ladder of periods, shortest first.
    function automatic logic [1:0] presc_rank(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b01:   r = 2'd0;
            2'b00:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/est_prescaler.sv
module est_prescaler
    import est_pkg::*;
#(
    parameter int BASE_SHIFT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] presc_sel,
    output logic       strobe
);
    localparam int DIV_W = BASE_SHIFT + 3;

    logic [1:0]       sel_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_tick;
    logic             sel_hit;

    always_comb begin
        last_tick = (DIV_W'(1) << (BASE_SHIFT + int'(presc_rank(sel_q)))) - DIV_W'(1);
        sel_hit   = (presc_sel == sel_q);
        strobe    = sel_hit && (div_q == last_tick);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= presc_sel;
            div_q <= '0;
        end else if (!sel_hit) begin
            sel_q <= presc_sel;
            div_q <= '0;
        end else if (div_q == last_tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R2: strobes are never back to back
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R9: a code change suppresses the strobe on the following clock
    p_restart_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_hit |=> !strobe);

endmodule

// File: rtl/est_sampler.sv
module est_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic pin_in,
    output logic level,
    output logic sample_q,
    output logic valid_q
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            sample_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            if (strobe) begin
                sample_q <= sync_q[SYNC_STAGES-1];
                valid_q  <= 1'b1;
            end
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    // R3: the held sample moves only on strobe cycles
    p_sample_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(sample_q));

endmodule

// File: rtl/est_ctrl.sv
module est_ctrl
    import est_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [1:0]       run_mode,
    input  logic [1:0]       edge_sel,
    input  logic             cnt_level,
    input  logic             cnt_prev,
    input  logic             cnt_valid,
    input  logic             gate_level,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    est_state_e state_q, state_d;
    logic       rise_ev, fall_ev, edge_hit, inc;

    // next-state selection: GO_IDLE / GO_GATED / GO_COUNT
    always_comb begin
        unique case (run_mode)
            MODE_GATED: state_d = ST_GATED;
            MODE_COUNT: state_d = ST_COUNT;
            MODE_STOP:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output decode: increment request per state
    always_comb begin
        rise_ev = strobe && cnt_valid &&  cnt_level && !cnt_prev;
        fall_ev = strobe && cnt_valid && !cnt_level &&  cnt_prev;
        unique case (edge_sel)
            EDGE_RISE: edge_hit = rise_ev;
            EDGE_FALL: edge_hit = fall_ev;
            EDGE_BOTH: edge_hit = rise_ev || fall_ev;
            default:   edge_hit = 1'b0;
        endcase
        unique case (state_q)
            ST_GATED: inc = strobe && gate_level;
            ST_COUNT: inc = edge_hit;
            ST_IDLE:  inc = 1'b0;
            default:  inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc && (count == CNT_MAX);
            if (inc) count <= count + CNT_W'(1);
        end
    end

    // R8: overflow lasts one clock and coincides with a zero count
    p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);
    p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0));

    // R7: stopped state freezes the value
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> $stable(count));

    // R6: no strobe, no step
    p_no_step_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(count));

    // R5: no edge before a first sample is held
    p_first_sample_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_COUNT) && !cnt_valid) |=> $stable(count));

endmodule

// File: rtl/ext_sample_timer.sv
module ext_sample_timer
    import est_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BASE_SHIFT  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       presc_sel,
    input  logic [1:0]       run_mode,
    input  logic [1:0]       edge_sel,
    input  logic             cnt_pin,
    input  logic             gate_pin,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int N_CH = 2;
    localparam int CH_CNT  = 0;
    localparam int CH_GATE = 1;

    logic            strobe;
    logic [N_CH-1:0] pins, lvl, prev, vld;

    assign pins = {gate_pin, cnt_pin};

    est_prescaler #(.BASE_SHIFT(BASE_SHIFT)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .presc_sel (presc_sel),
        .strobe    (strobe)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        est_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
            .clk      (clk),
            .rst      (rst),
            .strobe   (strobe),
            .pin_in   (pins[ch]),
            .level    (lvl[ch]),
            .sample_q (prev[ch]),
            .valid_q  (vld[ch])
        );
    end

    est_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .run_mode   (run_mode),
        .edge_sel   (edge_sel),
        .cnt_level  (lvl[CH_CNT]),
        .cnt_prev   (prev[CH_CNT]),
        .cnt_valid  (vld[CH_CNT]),
        .gate_level (lvl[CH_GATE]),
        .count      (count),
        .ovf        (ovf)
    );

    logic unused_gate;
    assign unused_gate = ^{prev[CH_GATE], vld[CH_GATE]};

endmodule

// File: tb/test_ext_sample_timer.sv
`timescale 1ns/1ps
module test_ext_sample_timer;
    localparam int CW = 10;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    presc_sel = 2'b01;
    logic [1:0]    run_mode = 2'b00;
    logic [1:0]    edge_sel = 2'b00;
    logic          cnt_pin = 1'b0;
    logic          gate_pin = 1'b0;
    logic [CW-1:0] count;
    logic          ovf;

    int    n_checks = 0;
    int    n_fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    ext_sample_timer #(.CNT_W(CW)) i_ext_sample_timer (
        .clk(clk), .rst(rst), .presc_sel(presc_sel), .run_mode(run_mode),
        .edge_sel(edge_sel), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .count(count), .ovf(ovf)
    );

    always #2.5 clk = ~clk;

    function automatic int period_of(input logic [1:0] c);
        case (c)
            2'b01:   return 4;
            2'b00:   return 8;
            2'b11:   return 16;
            default: return 32;
        endcase
    endfunction

    // behavioural reference
    int       m_div, m_state, m_cnt;
    logic [1:0] m_sel;
    logic     m_c1, m_c2, m_g1, m_g2, m_csamp, m_valid, m_ovf;
    logic     t_stb, t_rise, t_fall, t_hit, t_inc;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_sel = presc_sel; m_state = 0; m_cnt = 0; m_ovf = 0;
            m_c1 = 0; m_c2 = 0; m_g1 = 0; m_g2 = 0; m_csamp = 0; m_valid = 0;
        end else begin
            t_stb  = (presc_sel == m_sel) && (m_div == period_of(m_sel) - 1);
            t_rise = t_stb && m_valid && m_c2 && !m_csamp;
            t_fall = t_stb && m_valid && !m_c2 && m_csamp;
            case (edge_sel)
                2'b01:   t_hit = t_rise;
                2'b10:   t_hit = t_fall;
                2'b11:   t_hit = t_rise || t_fall;
                default: t_hit = 1'b0;
            endcase
            t_inc = (m_state == 2 && t_hit) || (m_state == 1 && t_stb && m_g2);
            m_ovf = t_inc && (m_cnt == MAXV);
            if (t_inc) m_cnt = (m_cnt + 1) % (MAXV + 1);
            m_state = (run_mode == 2'b01) ? 1 : (run_mode == 2'b10) ? 2 : 0;
            if (presc_sel != m_sel) begin m_sel = presc_sel; m_div = 0; end
            else if (t_stb) m_div = 0;
            else m_div = m_div + 1;
            if (t_stb) begin m_csamp = m_c2; m_valid = 1'b1; end
            m_c2 = m_c1; m_c1 = cnt_pin;
            m_g2 = m_g1; m_g1 = gate_pin;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(int'(count) == m_cnt, cur_req, "model count", int'(count), m_cnt);
            check(ovf == m_ovf, cur_req, "model ovf", int'(ovf), int'(m_ovf));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1'b1; wait_n(hi);
            cnt_pin = 1'b0; wait_n(lo);
        end
    endtask

    function automatic int delta(input int a, input int b);
        return (a - b) & MAXV;
    endfunction

    initial begin
        int c0;
        wait_n(3);
        check(count == 0, "R1", "count in reset", int'(count), 0);
        check(ovf == 0, "R1", "ovf in reset", int'(ovf), 0);
        rst = 1'b0;
        wait_n(1);
        check(count == 0, "R1", "count after reset", int'(count), 0);

        // R2 period per code
        cur_req = "R2";
        run_mode = 2'b01; gate_pin = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] code;
            code = (k == 0) ? 2'b01 : (k == 1) ? 2'b00 : (k == 2) ? 2'b11 : 2'b10;
            presc_sel = code;
            wait_n(40);
            c0 = int'(count);
            wait_n(8 * period_of(code));
            check(delta(int'(count), c0) == 8, "R2", "8 periods", delta(int'(count), c0), 8);
        end

        // R9 restart on code change
        cur_req = "R9";
        presc_sel = 2'b01;
        wait_n(20);
        c0 = int'(count);
        presc_sel = 2'b10;
        wait_n(32);
        check(int'(count) == c0, "R9", "no step before new period", int'(count), c0);
        wait_n(1);
        check(delta(int'(count), c0) == 1, "R9", "first step", delta(int'(count), c0), 1);
        wait_n(32);
        check(delta(int'(count), c0) == 2, "R9", "second step", delta(int'(count), c0), 2);

        // R6 gate low holds
        cur_req = "R6";
        presc_sel = 2'b01;
        gate_pin = 1'b0;
        wait_n(12);
        c0 = int'(count);
        wait_n(60);
        check(int'(count) == c0, "R6", "gate low hold", int'(count), c0);
        gate_pin = 1'b1;
        wait_n(60);
        check(delta(int'(count), c0) >= 14, "R6", "gate high steps", delta(int'(count), c0), 15);

        // R4 edge selections
        cur_req = "R4";
        run_mode = 2'b10; gate_pin = 1'b0;
        for (int e = 0; e < 4; e++) begin
            int exp;
            edge_sel = 2'(e);
            exp = (e == 0) ? 0 : (e == 3) ? 10 : 5;
            wait_n(20);
            c0 = int'(count);
            pulses(5, 8, 8);
            wait_n(20);
            check(delta(int'(count), c0) == exp, "R4", "edge count", delta(int'(count), c0), exp);
        end

        // R3 pulse between strobes is missed
        cur_req = "R3";
        edge_sel = 2'b11;
        wait_n(20);
        c0 = int'(count);
        presc_sel = 2'b10;
        wait_n(8);
        cnt_pin = 1'b1; wait_n(2); cnt_pin = 1'b0;
        wait_n(100);
        check(int'(count) == c0, "R3", "short pulse ignored", int'(count), c0);

        // R10 half-rate toggling
        cur_req = "R10";
        presc_sel = 2'b01;
        wait_n(20);
        c0 = int'(count);
        for (int i = 0; i < 20; i++) begin
            cnt_pin = ~cnt_pin; wait_n(4);
        end
        wait_n(16);
        check(delta(int'(count), c0) == 20, "R10", "half rate toggles", delta(int'(count), c0), 20);

        // R7 stop codes hold the count
        cur_req = "R7";
        for (int m = 0; m < 2; m++) begin
            run_mode = (m == 0) ? 2'b00 : 2'b11;
            gate_pin = 1'b1;
            wait_n(2);
            c0 = int'(count);
            pulses(4, 8, 8);
            wait_n(20);
            check(int'(count) == c0, "R7", "stopped hold", int'(count), c0);
        end

        // R5 first sample after reset is not an edge
        cur_req = "R5";
        rst = 1'b1; cnt_pin = 1'b1; run_mode = 2'b10; edge_sel = 2'b01;
        presc_sel = 2'b01; gate_pin = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(40);
        check(count == 0, "R5", "no count from first sample", int'(count), 0);
        cnt_pin = 1'b0; wait_n(12); cnt_pin = 1'b1; wait_n(16);
        check(count == 1, "R5", "later rise counted", int'(count), 1);

        // R8 wrap and overflow pulse
        cur_req = "R8";
        rst = 1'b1; run_mode = 2'b01; gate_pin = 1'b1;
        wait_n(2);
        rst = 1'b0;
        for (int i = 0; i < 6000 && int'(count) != MAXV; i++) wait_n(1);
        check(int'(count) == MAXV, "R8", "reached max", int'(count), MAXV);
        check(ovf == 0, "R8", "no ovf at max", int'(ovf), 0);
        for (int i = 0; i < 10 && int'(count) == MAXV; i++) wait_n(1);
        check(count == 0, "R8", "wrap to zero", int'(count), 0);
        check(ovf == 1, "R8", "ovf on wrap", int'(ovf), 1);
        wait_n(1);
        check(ovf == 0, "R8", "ovf one clock", int'(ovf), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule